// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address. It reads one or two descriptor words from a two-level translation table held in memory. A walk begins when a start request carrying the virtual address arrives while the walker is idle. The walker then issues a word read for the first-level descriptor, at an address derived from the table base input. That descriptor either maps a whole 1 MiB section, points to a coarse or fine second-level table, or reports a fault.

When a second-level table is used, a second word read fetches a page descriptor. That descriptor maps a large (64 KiB), small (4 KiB) or tiny (1 KiB) page. Each kind of mapping has its own rule for joining descriptor and address bits, and its own width of access-permission field. A configuration input decides whether fine tables, the only route to tiny pages, are allowed at all.

The results appear together during a single-cycle done pulse: physical address, page kind, domain, cacheable/bufferable bits, access-permission bits and a fault flag. They stay on the outputs until the next walk completes. Only one walk is in flight at a time. Checking permissions and caching translations are left to the logic that surrounds the block.

Top module: `xw_walker`

## Requirements
- R1: A start request is taken only while `busy` is low; a start pulse during a walk is ignored and does not alter the walk. `busy` rises the cycle after acceptance and stays high until the cycle in which `done` is high for exactly one cycle, with `busy` low in that cycle.
- R2: The first read is issued the cycle after acceptance at address {tbase[31:14], vaddr[31:20], 2'b00}. `mem_req` and `mem_addr` stay unchanged until a cycle with `mem_valid` high, and the descriptor is taken from `mem_rdata` in that cycle.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after one read with `fault`=1. The fault result also sets `ptype`=7, `pa`=0, `domain`=0, `cb`=0 and `ap`=0.
- R4: A first-level descriptor with bits [1:0] = 11 is a fault, reported as in R3 with no second read, when `tiny_en` is 0.
- R5: A first-level descriptor with bits [1:0] = 10 is a section and completes without a second read. Its results are `ptype`=0, `pa`={d[31:20], vaddr[19:0]}, `cb`=d[3:2] and `ap`={6'b0, d[11:10]}.
- R6: A first-level descriptor with bits [1:0] = 01 (coarse table) causes a second read at {d[31:10], vaddr[19:12], 2'b00}, issued the cycle after the first descriptor is taken.
- R7: A first-level descriptor with bits [1:0] = 11 and `tiny_en`=1 (fine table) causes a second read at {d[31:12], vaddr[19:10], 2'b00}.
- R8: A second-level descriptor e with bits [1:0] = 01 is a large page. Its results are `ptype`=1, `pa`={e[31:16], vaddr[15:0]}, `cb`=e[3:2] and `ap`=e[11:4].
- R9: A second-level descriptor with bits [1:0] = 10 is a small page. Its results are `ptype`=2, `pa`={e[31:12], vaddr[11:0]}, `cb`=e[3:2] and `ap`=e[11:4].
- R10: A second-level descriptor with bits [1:0] = 11 is a tiny page. Its results are `ptype`=3, `pa`={e[31:10], vaddr[9:0]}, `cb`=e[3:2] and `ap`={6'b0, e[5:4]}.
- R11: A second-level descriptor with bits [1:0] = 00 gives a fault result as in R3.
- R12: For every result that is not a fault, `domain` equals bits [8:5] of the first-level descriptor.
- R13: A synchronous active-high `rst` returns the walker to idle the cycle after it is sampled. After reset `mem_req`, `busy`, `done`, `fault` and `pa` are 0 and `ptype` is 7, even when reset arrives in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tiny_en | input | 1 | Allows fine second-level tables and tiny pages |
| tbase | input | 32 | Translation table base; bits 31:14 used |
| start | input | 1 | Walk request, taken when idle |
| vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation fault result |
| pa | output | 32 | Physical address result |
| ptype | output | 3 | 0 section, 1 large, 2 small, 3 tiny, 7 fault |
| domain | output | 4 | Domain number |
| cb | output | 2 | Cacheable/bufferable bits |
| ap | output | 8 | Access-permission bits |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_valid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data |

## Verification
The first descriptor read is due one cycle after start is accepted. A second read, when there is one, is due one cycle after the cycle in which the first `mem_valid` is seen. `done` and all results are due one cycle after the last `mem_valid`. The bench drives inputs on falling edges and samples on falling edges at exactly those offsets. It holds memory latency between one and three cycles and confirms that the request is still held in each waiting cycle. It sweeps every first-level and second-level type code against both `tiny_en` settings and several addresses, and compares each output against masks and shifts computed in the bench.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int ADDR_W = 32;
    localparam int DOM_W  = 4;
    localparam int CB_W   = 2;
    localparam int AP_W   = 8;
    localparam int KIND_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH1 = 2'd1,
        ST_FETCH2 = 2'd2
    } walk_state_e;

    typedef enum logic [KIND_W-1:0] {
        PK_SECTION = 3'd0,
        PK_LARGE   = 3'd1,
        PK_SMALL   = 3'd2,
        PK_TINY    = 3'd3,
        PK_NONE    = 3'd7
    } page_kind_e;

    typedef enum logic [1:0] {
        L1_FAULT,
        L1_SECTION,
        L1_COARSE,
        L1_FINE
    } l1_kind_e;

    typedef struct packed {
        walk_state_e       st;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] maddr;
        logic [DOM_W-1:0]  wdom;
        logic [ADDR_W-1:0] pa;
        page_kind_e        kind;
        logic [DOM_W-1:0]  dom;
        logic [CB_W-1:0]   cb;
        logic [AP_W-1:0]   ap;
        logic              fault;
        logic              done;
    } walk_regs_t;

    localparam walk_regs_t WALK_RESET = '{
        st:    ST_IDLE,
        va:    '0,
        maddr: '0,
        wdom:  '0,
        pa:    '0,
        kind:  PK_NONE,
        dom:   '0,
        cb:    '0,
        ap:    '0,
        fault: 1'b0,
        done:  1'b0
    };
endpackage

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    input  logic              tiny_en,
    output l1_kind_e          kind,
    output logic [ADDR_W-1:0] next_addr,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [DOM_W-1:0]  dom,
    output logic [CB_W-1:0]   cb,
    output logic [AP_W-1:0]   ap
);
    localparam int SECT_LO = 20;

    always_comb begin
        dom       = desc[8:5];
        cb        = desc[3:2];
        ap        = {{(AP_W-2){1'b0}}, desc[11:10]};
        sect_pa   = {desc[ADDR_W-1:SECT_LO], va[SECT_LO-1:0]};
        next_addr = '0;
        kind      = L1_FAULT;
        case (desc[1:0])
            2'b01: begin
                kind      = L1_COARSE;
                next_addr = {desc[ADDR_W-1:10], va[19:12], 2'b00};
            end
            2'b10: kind = L1_SECTION;
            2'b11: begin
                if (tiny_en) begin
                    kind      = L1_FINE;
                    next_addr = {desc[ADDR_W-1:12], va[19:10], 2'b00};
                end
            end
            default: kind = L1_FAULT;
        endcase
    end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
    import xw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [ADDR_W-1:0] va,
    output logic              fault,
    output page_kind_e        kind,
    output logic [ADDR_W-1:0] pa,
    output logic [CB_W-1:0]   cb,
    output logic [AP_W-1:0]   ap
);
    always_comb begin
        cb    = desc[3:2];
        fault = 1'b0;
        case (desc[1:0])
            2'b01: begin
                kind = PK_LARGE;
                pa   = {desc[ADDR_W-1:16], va[15:0]};
                ap   = desc[11:4];
            end
            2'b10: begin
                kind = PK_SMALL;
                pa   = {desc[ADDR_W-1:12], va[11:0]};
                ap   = desc[11:4];
            end
            2'b11: begin
                kind = PK_TINY;
                pa   = {desc[ADDR_W-1:10], va[9:0]};
                ap   = {{(AP_W-2){1'b0}}, desc[5:4]};
            end
            default: begin
                kind  = PK_NONE;
                pa    = '0;
                ap    = '0;
                fault = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tiny_en,
    input  logic [ADDR_W-1:0] tbase,
    input  logic              start,
    input  logic [ADDR_W-1:0] vaddr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] pa,
    output logic [KIND_W-1:0] ptype,
    output logic [DOM_W-1:0]  domain,
    output logic [CB_W-1:0]   cb,
    output logic [AP_W-1:0]   ap,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata
);
    localparam int TB_LO = 14;

    walk_regs_t r_d, r_q;

    l1_kind_e          l1_kind;
    logic [ADDR_W-1:0] l1_next, l1_pa;
    logic [DOM_W-1:0]  l1_dom;
    logic [CB_W-1:0]   l1_cb;
    logic [AP_W-1:0]   l1_ap;

    logic              l2_fault;
    page_kind_e        l2_kind;
    logic [ADDR_W-1:0] l2_pa;
    logic [CB_W-1:0]   l2_cb;
    logic [AP_W-1:0]   l2_ap;

    xw_l1_decode u_l1 (
        .desc      (mem_rdata),
        .va        (r_q.va),
        .tiny_en   (tiny_en),
        .kind      (l1_kind),
        .next_addr (l1_next),
        .sect_pa   (l1_pa),
        .dom       (l1_dom),
        .cb        (l1_cb),
        .ap        (l1_ap)
    );

    xw_l2_decode u_l2 (
        .desc  (mem_rdata),
        .va    (r_q.va),
        .fault (l2_fault),
        .kind  (l2_kind),
        .pa    (l2_pa),
        .cb    (l2_cb),
        .ap    (l2_ap)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_FETCH1;
                    r_d.va    = vaddr;
                    r_d.maddr = {tbase[ADDR_W-1:TB_LO], vaddr[31:20], 2'b00};
                end
            end
            ST_FETCH1: begin
                if (mem_valid) begin
                    r_d.wdom = l1_dom;
                    case (l1_kind)
                        L1_SECTION: begin
                            r_d.st    = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.fault = 1'b0;
                            r_d.kind  = PK_SECTION;
                            r_d.pa    = l1_pa;
                            r_d.dom   = l1_dom;
                            r_d.cb    = l1_cb;
                            r_d.ap    = l1_ap;
                        end
                        L1_COARSE, L1_FINE: begin
                            r_d.st    = ST_FETCH2;
                            r_d.maddr = l1_next;
                        end
                        default: begin
                            r_d.st    = ST_IDLE;
                            r_d.done  = 1'b1;
                            r_d.fault = 1'b1;
                            r_d.kind  = PK_NONE;
                            r_d.pa    = '0;
                            r_d.dom   = '0;
                            r_d.cb    = '0;
                            r_d.ap    = '0;
                        end
                    endcase
                end
            end
            ST_FETCH2: begin
                if (mem_valid) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fault = l2_fault;
                    r_d.kind  = l2_kind;
                    r_d.pa    = l2_pa;
                    r_d.dom   = l2_fault ? '0 : r_q.wdom;
                    r_d.cb    = l2_fault ? '0 : l2_cb;
                    r_d.ap    = l2_ap;
                end
            end
            default: r_d = WALK_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= WALK_RESET;
        else     r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign mem_req  = (r_q.st == ST_FETCH1) || (r_q.st == ST_FETCH2);
    assign mem_addr = r_q.maddr;
    assign done     = r_q.done;
    assign fault    = r_q.fault;
    assign pa       = r_q.pa;
    assign ptype    = r_q.kind;
    assign domain   = r_q.dom;
    assign cb       = r_q.cb;
    assign ap       = r_q.ap;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [31:0] pa,
    input logic [2:0]  ptype,
    input logic [3:0]  domain,
    input logic [1:0]  cb,
    input logic [7:0]  ap,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_valid
);
    // R1
    start_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (pa == 32'd0 && ptype == 3'd7 && domain == 4'd0 && cb == 2'd0 && ap == 8'd0));
    // R3
    fault_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (ptype <= 3'd3));
    // R13
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && !done));
endmodule

bind xw_walker xw_walker_chk u_chk (.*);

// File: tb/sim_xw_walker.sv
module sim_xw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tiny_en = 1'b0;
    logic [31:0] tbase = 32'h0;
    logic        start = 1'b0;
    logic [31:0] vaddr = 32'h0;
    logic        busy, done, fault, mem_req;
    logic [31:0] pa, mem_addr;
    logic [2:0]  ptype;
    logic [3:0]  domain;
    logic [1:0]  cb;
    logic [7:0]  ap;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    xw_walker u0 (
        .clk(clk), .rst(rst), .tiny_en(tiny_en), .tbase(tbase),
        .start(start), .vaddr(vaddr), .busy(busy), .done(done),
        .fault(fault), .pa(pa), .ptype(ptype), .domain(domain),
        .cb(cb), .ap(ap), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // one full walk with bench-computed expectations
    task automatic walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                        input int lat, input bit poke);
        bit two, ef;
        logic [31:0] a1, a2, epa;
        logic [2:0]  ek;
        logic [3:0]  ed;
        logic [1:0]  ec;
        logic [7:0]  ea;
        string ptag, atag;
        a1 = (tbase & 32'hFFFF_C000) | ((va >> 20) << 2);
        two = 0; a2 = 0; ef = 0; epa = 0; ek = 3'd7; ed = 0; ec = 0; ea = 0;
        ptag = "R3"; atag = "R6";
        case (d1 & 3)
            0: begin ef = 1; ptag = "R3"; end
            1: begin two = 1; atag = "R6";
                     a2 = (d1 & 32'hFFFF_FC00) | (((va >> 12) & 32'hFF) << 2); end
            2: begin ptag = "R5"; ek = 0; epa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
                     ed = 4'((d1 >> 5) & 15); ec = 2'((d1 >> 2) & 3); ea = 8'((d1 >> 10) & 3); end
            default: begin
                if (tiny_en) begin two = 1; atag = "R7";
                    a2 = (d1 & 32'hFFFF_F000) | (((va >> 10) & 32'h3FF) << 2); end
                else begin ef = 1; ptag = "R4"; end
            end
        endcase
        if (two) begin
            ed = 4'((d1 >> 5) & 15); ec = 2'((d2 >> 2) & 3);
            case (d2 & 3)
                0: begin ef = 1; ptag = "R11"; ed = 0; ec = 0; end
                1: begin ptag = "R8"; ek = 1; epa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF); ea = 8'((d2 >> 4) & 255); end
                2: begin ptag = "R9"; ek = 2; epa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF); ea = 8'((d2 >> 4) & 255); end
                default: begin ptag = "R10"; ek = 3; epa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF); ea = 8'((d2 >> 4) & 3); end
            endcase
        end

        @(negedge clk); start = 1; vaddr = va;
        @(negedge clk); start = 0;
        chk("R1 busy after accept", {31'd0, busy}, 32'd1);
        chk("R2 first read addr", mem_addr, a1);
        for (int j = 0; j < lat; j++) begin
            if (poke && j == 0) begin start = 1; vaddr = ~va; end
            @(negedge clk); start = 0;
            chk("R2 request held", {31'd0, mem_req}, 32'd1);
            chk("R2 address held", mem_addr, a1);
        end
        mem_valid = 1; mem_rdata = d1;
        @(negedge clk); mem_valid = 0; mem_rdata = 32'hDEAD_BEEF;
        if (two) begin
            chk("R6 R7 no early done", {31'd0, done}, 32'd0);
            chk({atag, " second read addr"}, mem_addr, a2);
            for (int j = 0; j < lat; j++) begin
                @(negedge clk);
                chk("R2 second request held", {31'd0, mem_req}, 32'd1);
            end
            mem_valid = 1; mem_rdata = d2;
            @(negedge clk); mem_valid = 0;
        end
        chk({ptag, " done pulse"}, {31'd0, done}, 32'd1);
        chk("R1 busy low at done", {31'd0, busy}, 32'd0);
        chk({ptag, " fault"}, {31'd0, fault}, {31'd0, ef});
        chk({ptag, " pa"}, pa, epa);
        chk({ptag, " ptype"}, {29'd0, ptype}, {29'd0, ek});
        chk({ptag, " cb"}, {30'd0, cb}, {30'd0, ec});
        chk({ptag, " ap"}, {24'd0, ap}, {24'd0, ea});
        chk("R12 domain", {28'd0, domain}, {28'd0, ed});
        @(negedge clk);
        chk("R1 done one cycle", {31'd0, done}, 32'd0);
        chk("R1 idle after walk", {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        logic [31:0] va, d1, d2;
        tbase = 32'hA5A5_7FFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R13 reset busy", {31'd0, busy}, 32'd0);
        chk("R13 reset req", {31'd0, mem_req}, 32'd0);
        chk("R13 reset done", {31'd0, done}, 32'd0);
        chk("R13 reset fault", {31'd0, fault}, 32'd0);
        chk("R13 reset pa", pa, 32'd0);
        chk("R13 reset ptype", {29'd0, ptype}, 32'd7);

        for (int te = 0; te < 2; te++) begin
            for (int t1 = 0; t1 < 4; t1++) begin
                for (int t2 = 0; t2 < 4; t2++) begin
                    for (int k = 0; k < 3; k++) begin
                        tiny_en = te[0];
                        va = 32'h9E37_79B9 * (t1 * 16 + t2 * 4 + k + 1) ^ {k[7:0], 24'h5A3C1};
                        d1 = ((32'h85EB_CA6B * (t2 + 3 * k + 7)) & ~32'h3) | t1;
                        d2 = ((32'hC2B2_AE35 * (t1 + 5 * k + 11)) & ~32'h3) | t2;
                        walk(va, d1, d2, 1 + (k + t2) % 3, k == 1);
                    end
                end
            end
            tbase = 32'h1234_4000;
        end

        // R13 reset in the middle of a walk
        @(negedge clk); start = 1; vaddr = 32'h7654_3210;
        @(negedge clk); start = 0;
        chk("R13 walk started", {31'd0, mem_req}, 32'd1);
        rst = 1;
        @(negedge clk); rst = 0;
        chk("R13 mid-walk reset req", {31'd0, mem_req}, 32'd0);
        chk("R13 mid-walk reset busy", {31'd0, busy}, 32'd0);
        chk("R13 mid-walk reset ptype", {29'd0, ptype}, 32'd7);
        tiny_en = 1;
        walk(32'h0ABC_DEF1, 32'h0000_1ABF, 32'hFFFF_FFF3, 2, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule